// File: doc/BRIEF.md
# Superpriority Interrupt Take Selector

This block decides which pending interrupt request a processor core takes next. It has seven request lines: physical IRQ, FIQ and NMI, and the virtual IRQ, FIQ, IRQ-NMI and FIQ-NMI. It combines them with the current privilege level, the routed target level of the physical requests, the processor mask flags (I, F, the all-interrupt flag and the stack-select flag) and the per-level control bits. The virtual requests always target level 1.

An all-interrupt mask can block every class at once. The stack-select flag can extend that mask when the level's stack-interrupt-mask control is set. When superpriority handling is disabled for the current level, each superpriority request falls back to its ordinary class.

The choice is made combinationally and registered by a two-state machine. `SEL_IDLE` moves to `SEL_ISSUE` when an eligible request exists (transition *grant*). `SEL_ISSUE` always returns to `SEL_IDLE` (transition *release*). The take strobe is high only in `SEL_ISSUE`. In the same edge the block latches three values: the exception index, the vector offset, and the all-interrupt value the core must load on entry.

Top module: `sip_take_sel`

## Requirements
- R1: A request whose target level (the routed physical level for IRQ, FIQ and NMI; level 1 for every virtual class) is numerically below `cur_el` is never taken.
- R2: For a target level T, the all-interrupt mask is active only if `nmi_en[T]`=1 and `cur_el`=T. When active, its value is `pst_allint` OR (`spint_mask[T]` AND `pst_spsel`). Otherwise it is 0. This includes the case `pst_allint`=0 with `spint_mask[T]`=1 and `pst_spsel`=1, which masks.
- R3: A physical NMI (with `nmi_en[cur_el]`=1) is taken whenever the mask for its target is inactive, whatever the value of `pst_i`.
- R4: A physical IRQ needs `pst_i`=0 and an inactive mask. A physical FIQ needs `pst_f`=0 and an inactive mask.
- R5: A virtual IRQ-class request (IRQ or IRQ-NMI) needs `hyp_irq_route`=1 and `host_mode`=0. A virtual FIQ-class request needs `hyp_fiq_route`=1 and `host_mode`=0. Both classes also need the level-1 mask to be inactive. The ordinary virtual classes also need `pst_i`=0 or `pst_f`=0 respectively.
- R6: With `nmi_en[cur_el]`=1, the priority from highest to lowest is NMI, virtual IRQ-NMI, virtual FIQ-NMI, FIQ, IRQ, virtual IRQ, virtual FIQ.
- R7: With `nmi_en[cur_el]`=0, NMI is handled as IRQ, virtual IRQ-NMI as virtual IRQ, and virtual FIQ-NMI as virtual FIQ. This covers both the masking and the reported index.
- R8: `exc_idx` encodes IRQ=5, FIQ=6, virtual IRQ=14, virtual FIQ=15, NMI=26, virtual IRQ-NMI=27, virtual FIQ-NMI=28.
- R9: `vec_off` is 0x080 for IRQ, virtual IRQ, NMI and virtual IRQ-NMI. It is 0x100 for FIQ, virtual FIQ and virtual FIQ-NMI.
- R10: `entry_allint` is 1 when `spint_mask` of the taken request's target level is 0, and 0 when it is 1.
- R11: `take` rises in the cycle after the edge that sampled an eligible request and lasts exactly one cycle. While a request stays pending, takes come every second cycle. `exc_idx`, `vec_off` and `entry_allint` hold their values between takes.
- R12: After reset, `take`, `exc_idx`, `vec_off` and `entry_allint` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_irq | input | 1 | Physical IRQ pending |
| req_fiq | input | 1 | Physical FIQ pending |
| req_nmi | input | 1 | Physical superpriority IRQ pending |
| req_virq | input | 1 | Virtual IRQ pending |
| req_vfiq | input | 1 | Virtual FIQ pending |
| req_vinmi | input | 1 | Virtual superpriority IRQ pending |
| req_vfnmi | input | 1 | Virtual superpriority FIQ pending |
| cur_el | input | EL_W (2) | Current privilege level |
| irq_tgt_el | input | EL_W (2) | Routed target level of physical IRQ and NMI |
| fiq_tgt_el | input | EL_W (2) | Routed target level of physical FIQ |
| pst_i | input | 1 | IRQ mask flag |
| pst_f | input | 1 | FIQ mask flag |
| pst_allint | input | 1 | All-interrupt mask flag |
| pst_spsel | input | 1 | Stack-select flag |
| nmi_en | input | 2**EL_W (4) | Per-level superpriority enable |
| spint_mask | input | 2**EL_W (4) | Per-level stack-interrupt-mask control |
| hyp_irq_route | input | 1 | Virtual IRQ classes routed to the hypervisor |
| hyp_fiq_route | input | 1 | Virtual FIQ classes routed to the hypervisor |
| host_mode | input | 1 | Host trap mode; blocks all virtual classes |
| take | output | 1 | One-cycle take strobe |
| exc_idx | output | IDX_W (5) | Exception index of the taken request |
| vec_off | output | VEC_W (12) | Vector offset of the taken request |
| entry_allint | output | 1 | All-interrupt flag value to load on entry |

## Verification
Every result is registered once. When a stimulus is applied before rising edge k, `take`, `exc_idx`, `vec_off` and `entry_allint` are all valid in the cycle after edge k. `take` then falls after edge k+1. The bench drives each stimulus on a falling edge and waits for one rising edge. It compares all four outputs on the next falling edge, against a reference function computed from the inputs it drove. It then removes the requests and confirms on the following falling edge that `take` has dropped. This returns the selector to `SEL_IDLE` before the next stimulus.

// File: rtl/sip_pkg.sv
package sip_pkg;

    // positions of request classes in priority order (0 = highest)
    localparam int unsigned N_CLS     = 7;
    localparam int unsigned POS_NMI   = 0;
    localparam int unsigned POS_VINMI = 1;
    localparam int unsigned POS_VFNMI = 2;
    localparam int unsigned POS_FIQ   = 3;
    localparam int unsigned POS_IRQ   = 4;
    localparam int unsigned POS_VIRQ  = 5;
    localparam int unsigned POS_VFIQ  = 6;
    localparam int unsigned POS_W     = $clog2(N_CLS);

    // target sources
    localparam int unsigned N_TGT   = 3;
    localparam int unsigned T_IRQ   = 0;
    localparam int unsigned T_FIQ   = 1;
    localparam int unsigned T_VIRT  = 2;
    localparam int unsigned VIRT_EL = 1;

    // exception indices
    localparam int unsigned EXC_IRQ   = 5;
    localparam int unsigned EXC_FIQ   = 6;
    localparam int unsigned EXC_VIRQ  = 14;
    localparam int unsigned EXC_VFIQ  = 15;
    localparam int unsigned EXC_NMI   = 26;
    localparam int unsigned EXC_VINMI = 27;
    localparam int unsigned EXC_VFNMI = 28;

    localparam int unsigned OFF_IRQ_GRP = 'h080;
    localparam int unsigned OFF_FIQ_GRP = 'h100;

    typedef enum logic {
        SEL_IDLE,
        SEL_ISSUE
    } sel_state_e;

    function automatic int unsigned pos_to_idx(input logic [POS_W-1:0] p);
        int unsigned r;
        unique case (int'(p))
            POS_NMI:   r = EXC_NMI;
            POS_VINMI: r = EXC_VINMI;
            POS_VFNMI: r = EXC_VFNMI;
            POS_FIQ:   r = EXC_FIQ;
            POS_IRQ:   r = EXC_IRQ;
            POS_VIRQ:  r = EXC_VIRQ;
            default:   r = EXC_VFIQ;
        endcase
        return r;
    endfunction

    function automatic int unsigned pos_to_tgt(input logic [POS_W-1:0] p);
        int unsigned r;
        unique case (int'(p))
            POS_NMI, POS_IRQ: r = T_IRQ;
            POS_FIQ:          r = T_FIQ;
            default:          r = T_VIRT;
        endcase
        return r;
    endfunction

    function automatic logic pos_is_fiq_grp(input logic [POS_W-1:0] p);
        return (int'(p) == POS_FIQ) || (int'(p) == POS_VFIQ) || (int'(p) == POS_VFNMI);
    endfunction

endpackage

// File: rtl/sip_allmask.sv
module sip_allmask #(
    parameter int unsigned EL_W = 2
) (
    input  logic [EL_W-1:0]         cur_el,
    input  logic [EL_W-1:0]         tgt_el,
    input  logic [(1<<EL_W)-1:0]    nmi_en,
    input  logic [(1<<EL_W)-1:0]    spint_mask,
    input  logic                    allint,
    input  logic                    spsel,
    output logic                    level_ok,
    output logic                    all_mask
);
    logic same_lvl;

    assign same_lvl = (cur_el == tgt_el);
    assign level_ok = (tgt_el >= cur_el);
    // mask only applies when the feature is on at the target and we stay at it
    assign all_mask = nmi_en[tgt_el] & same_lvl &
                      (allint | (spint_mask[tgt_el] & spsel));
endmodule

// File: rtl/sip_eligible.sv
module sip_eligible
    import sip_pkg::*;
(
    input  logic [N_CLS-1:0] req,
    input  logic             nmi_on,
    input  logic [N_TGT-1:0] lvl_ok,
    input  logic [N_TGT-1:0] mask,
    input  logic             pst_i,
    input  logic             pst_f,
    input  logic             imo,
    input  logic             fmo,
    input  logic             tge,
    output logic [N_CLS-1:0] ok
);
    logic [N_CLS-1:0] eff;
    logic             virt_i;
    logic             virt_f;
    logic             go_irq;
    logic             go_fiq;
    logic             go_virt;

    always_comb begin
        eff = req;
        if (!nmi_on) begin
            // superpriority falls back to its ordinary class
            eff[POS_IRQ]   = req[POS_IRQ]  | req[POS_NMI];
            eff[POS_VIRQ]  = req[POS_VIRQ] | req[POS_VINMI];
            eff[POS_VFIQ]  = req[POS_VFIQ] | req[POS_VFNMI];
            eff[POS_NMI]   = 1'b0;
            eff[POS_VINMI] = 1'b0;
            eff[POS_VFNMI] = 1'b0;
        end
    end

    assign virt_i  = imo & ~tge;
    assign virt_f  = fmo & ~tge;
    assign go_irq  = lvl_ok[T_IRQ]  & ~mask[T_IRQ];
    assign go_fiq  = lvl_ok[T_FIQ]  & ~mask[T_FIQ];
    assign go_virt = lvl_ok[T_VIRT] & ~mask[T_VIRT];

    always_comb begin
        ok            = '0;
        ok[POS_NMI]   = eff[POS_NMI]   & go_irq;
        ok[POS_IRQ]   = eff[POS_IRQ]   & go_irq & ~pst_i;
        ok[POS_FIQ]   = eff[POS_FIQ]   & go_fiq & ~pst_f;
        ok[POS_VINMI] = eff[POS_VINMI] & go_virt & virt_i;
        ok[POS_VFNMI] = eff[POS_VFNMI] & go_virt & virt_f;
        ok[POS_VIRQ]  = eff[POS_VIRQ]  & go_virt & virt_i & ~pst_i;
        ok[POS_VFIQ]  = eff[POS_VFIQ]  & go_virt & virt_f & ~pst_f;
    end
endmodule

// File: rtl/sip_pick.sv
module sip_pick #(
    parameter int unsigned N = 7,
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  ok,
    output logic          found,
    output logic [PW-1:0] pos
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (ok[k]) begin
                found = 1'b1;
                pos   = PW'(k);
            end
        end
    end
endmodule

// File: rtl/sip_take_sel.sv
module sip_take_sel
    import sip_pkg::*;
#(
    parameter int unsigned EL_W  = 2,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned VEC_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_irq,
    input  logic                  req_fiq,
    input  logic                  req_nmi,
    input  logic                  req_virq,
    input  logic                  req_vfiq,
    input  logic                  req_vinmi,
    input  logic                  req_vfnmi,
    input  logic [EL_W-1:0]       cur_el,
    input  logic [EL_W-1:0]       irq_tgt_el,
    input  logic [EL_W-1:0]       fiq_tgt_el,
    input  logic                  pst_i,
    input  logic                  pst_f,
    input  logic                  pst_allint,
    input  logic                  pst_spsel,
    input  logic [(1<<EL_W)-1:0]  nmi_en,
    input  logic [(1<<EL_W)-1:0]  spint_mask,
    input  logic                  hyp_irq_route,
    input  logic                  hyp_fiq_route,
    input  logic                  host_mode,
    output logic                  take,
    output logic [IDX_W-1:0]      exc_idx,
    output logic [VEC_W-1:0]      vec_off,
    output logic                  entry_allint
);
    logic [EL_W-1:0]  tgt_src [N_TGT];
    logic [N_TGT-1:0] lvl_ok;
    logic [N_TGT-1:0] tmask;
    logic [N_CLS-1:0] req_vec;
    logic [N_CLS-1:0] ok;
    logic             found;
    logic [POS_W-1:0] pos;
    logic             nmi_on;
    sel_state_e       state_q;
    sel_state_e       state_nx;

    assign tgt_src[T_IRQ]  = irq_tgt_el;
    assign tgt_src[T_FIQ]  = fiq_tgt_el;
    assign tgt_src[T_VIRT] = EL_W'(VIRT_EL);

    assign nmi_on = nmi_en[cur_el];

    always_comb begin
        req_vec            = '0;
        req_vec[POS_NMI]   = req_nmi;
        req_vec[POS_VINMI] = req_vinmi;
        req_vec[POS_VFNMI] = req_vfnmi;
        req_vec[POS_FIQ]   = req_fiq;
        req_vec[POS_IRQ]   = req_irq;
        req_vec[POS_VIRQ]  = req_virq;
        req_vec[POS_VFIQ]  = req_vfiq;
    end

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        sip_allmask #(.EL_W(EL_W)) u_mask (
            .cur_el     (cur_el),
            .tgt_el     (tgt_src[g]),
            .nmi_en     (nmi_en),
            .spint_mask (spint_mask),
            .allint     (pst_allint),
            .spsel      (pst_spsel),
            .level_ok   (lvl_ok[g]),
            .all_mask   (tmask[g])
        );
    end

    sip_eligible u_elig (
        .req    (req_vec),
        .nmi_on (nmi_on),
        .lvl_ok (lvl_ok),
        .mask   (tmask),
        .pst_i  (pst_i),
        .pst_f  (pst_f),
        .imo    (hyp_irq_route),
        .fmo    (hyp_fiq_route),
        .tge    (host_mode),
        .ok     (ok)
    );

    sip_pick #(.N(N_CLS)) u_pick (
        .ok    (ok),
        .found (found),
        .pos   (pos)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEL_IDLE:  state_nx = found ? SEL_ISSUE : SEL_IDLE;  // grant
            SEL_ISSUE: state_nx = SEL_IDLE;                      // release
            default:   state_nx = SEL_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_idx      <= '0;
            vec_off      <= '0;
            entry_allint <= 1'b0;
        end else if (state_q == SEL_IDLE && found) begin
            exc_idx      <= IDX_W'(pos_to_idx(pos));
            vec_off      <= pos_is_fiq_grp(pos) ? VEC_W'(OFF_FIQ_GRP) : VEC_W'(OFF_IRQ_GRP);
            entry_allint <= ~spint_mask[tgt_src[pos_to_tgt(pos)]];
        end
    end

    assign take = (state_q == SEL_ISSUE);

    // R11: strobe never lasts two cycles
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R8: only the seven defined indices appear
    p_idx_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (exc_idx inside {IDX_W'(EXC_IRQ), IDX_W'(EXC_FIQ), IDX_W'(EXC_VIRQ),
                                  IDX_W'(EXC_VFIQ), IDX_W'(EXC_NMI), IDX_W'(EXC_VINMI),
                                  IDX_W'(EXC_VFNMI)}));

    // R9: vector group agrees with index
    p_vec_grp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ((vec_off == VEC_W'(OFF_IRQ_GRP)) ==
                  (exc_idx inside {IDX_W'(EXC_IRQ), IDX_W'(EXC_VIRQ),
                                   IDX_W'(EXC_NMI), IDX_W'(EXC_VINMI)})));

    // R7: no superpriority index when the feature was off at the sampled level
    p_fold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($past(nmi_on) || exc_idx < IDX_W'(EXC_NMI)));

    // R5: virtual superpriority needs host mode clear
    p_virt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && exc_idx inside {IDX_W'(EXC_VINMI), IDX_W'(EXC_VFNMI)}) |-> !$past(host_mode));

    // R1: physical IRQ-group never taken to a lower level
    p_lower_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && exc_idx inside {IDX_W'(EXC_IRQ), IDX_W'(EXC_NMI)}) |->
            $past(irq_tgt_el >= cur_el));
endmodule

// File: tb/sip_take_sel_bench.sv
module sip_take_sel_bench;
    localparam int PERIOD = 10;
    localparam int EL_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_irq, req_fiq, req_nmi, req_virq, req_vfiq, req_vinmi, req_vfnmi;
    logic [EL_W-1:0] cur_el, irq_tgt_el, fiq_tgt_el;
    logic pst_i, pst_f, pst_allint, pst_spsel;
    logic [3:0] nmi_en, spint_mask;
    logic hyp_irq_route, hyp_fiq_route, host_mode;
    logic take;
    logic [4:0] exc_idx;
    logic [11:0] vec_off;
    logic entry_allint;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    sip_take_sel u_sip_take_sel (
        .clk(clk), .rst_n(rst_n),
        .req_irq(req_irq), .req_fiq(req_fiq), .req_nmi(req_nmi),
        .req_virq(req_virq), .req_vfiq(req_vfiq), .req_vinmi(req_vinmi), .req_vfnmi(req_vfnmi),
        .cur_el(cur_el), .irq_tgt_el(irq_tgt_el), .fiq_tgt_el(fiq_tgt_el),
        .pst_i(pst_i), .pst_f(pst_f), .pst_allint(pst_allint), .pst_spsel(pst_spsel),
        .nmi_en(nmi_en), .spint_mask(spint_mask),
        .hyp_irq_route(hyp_irq_route), .hyp_fiq_route(hyp_fiq_route), .host_mode(host_mode),
        .take(take), .exc_idx(exc_idx), .vec_off(vec_off), .entry_allint(entry_allint)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_reqs();
        {req_irq, req_fiq, req_nmi, req_virq, req_vfiq, req_vinmi, req_vfnmi} = '0;
    endtask

    task automatic defaults();
        clr_reqs();
        cur_el = 2'd1; irq_tgt_el = 2'd1; fiq_tgt_el = 2'd1;
        {pst_i, pst_f, pst_allint, pst_spsel} = '0;
        nmi_en = 4'hF; spint_mask = 4'h0;
        hyp_irq_route = 1'b1; hyp_fiq_route = 1'b1; host_mode = 1'b0;
    endtask

    // reference model, written from the requirements
    function automatic bit mask_at(input int t);
        if (nmi_en[t] !== 1'b1 || int'(cur_el) != t) return 1'b0;
        return pst_allint | (spint_mask[t] & pst_spsel);
    endfunction

    function automatic int ref_pick();
        bit on, e_irq, e_virq, e_vfiq, irq_path, fiq_path, v_path, vi, vf;
        on       = nmi_en[cur_el];
        irq_path = (irq_tgt_el >= cur_el) && !mask_at(int'(irq_tgt_el));
        fiq_path = (fiq_tgt_el >= cur_el) && !mask_at(int'(fiq_tgt_el));
        v_path   = (cur_el <= 2'd1) && !mask_at(1);
        vi       = hyp_irq_route && !host_mode;
        vf       = hyp_fiq_route && !host_mode;
        if (on) begin
            if (req_nmi && irq_path)        return 26;
            if (req_vinmi && vi && v_path)  return 27;
            if (req_vfnmi && vf && v_path)  return 28;
        end
        e_irq  = req_irq  || (!on && req_nmi);
        e_virq = req_virq || (!on && req_vinmi);
        e_vfiq = req_vfiq || (!on && req_vfnmi);
        if (req_fiq && fiq_path && !pst_f)         return 6;
        if (e_irq && irq_path && !pst_i)           return 5;
        if (e_virq && vi && v_path && !pst_i)      return 14;
        if (e_vfiq && vf && v_path && !pst_f)      return 15;
        return 0;
    endfunction

    function automatic int ref_vec(input int e);
        return (e == 6 || e == 15 || e == 28) ? 'h100 : 'h080;
    endfunction

    function automatic int ref_allint(input int e);
        int t;
        if (e == 5 || e == 26) t = int'(irq_tgt_el);
        else if (e == 6)       t = int'(fiq_tgt_el);
        else                   t = 1;
        return spint_mask[t] ? 0 : 1;
    endfunction

    // inputs already driven at a falling edge with the selector idle
    task automatic run_vec(input string tag);
        int e, ev, ea;
        e  = ref_pick();
        ev = ref_vec(e);
        ea = ref_allint(e);
        @(posedge clk); @(negedge clk);
        cmp({tag, " take"}, int'(take), (e != 0) ? 1 : 0);
        if (e != 0) begin
            cmp({tag, " idx R8"}, int'(exc_idx), e);
            cmp({tag, " vec R9"}, int'(vec_off), ev);
            cmp({tag, " allint R10"}, int'(entry_allint), ea);
        end
        clr_reqs();
        @(posedge clk); @(negedge clk);
        cmp("R11 strobe low", int'(take), 0);
    endtask

    task automatic t_reset();
        cmp("R12 take", int'(take), 0);
        cmp("R12 idx", int'(exc_idx), 0);
        cmp("R12 vec", int'(vec_off), 0);
        cmp("R12 allint", int'(entry_allint), 0);
    endtask

    // R2 R3 R4: every mask-flag combination, including allint=0 with spint=1 and spsel=1
    task automatic t_mask_sweep();
        for (int same = 0; same < 2; same++)
        for (int nen = 0; nen < 2; nen++)
        for (int am = 0; am < 2; am++)
        for (int sp = 0; sp < 2; sp++)
        for (int sm = 0; sm < 2; sm++)
        for (int ib = 0; ib < 2; ib++)
        for (int nq = 0; nq < 2; nq++) begin
            defaults();
            irq_tgt_el = same ? 2'd1 : 2'd2;
            nmi_en     = nen ? 4'hF : 4'h0;
            pst_allint = am[0];
            pst_spsel  = sp[0];
            spint_mask = sm ? 4'hF : 4'h0;
            pst_i      = ib[0];
            req_irq    = 1'b1;
            req_nmi    = nq[0];
            run_vec("R2/R3/R4 sweep");
        end
        // FIQ through its own mask (R4)
        defaults(); req_fiq = 1'b1; pst_f = 1'b1; run_vec("R4 fiq F set");
        defaults(); req_fiq = 1'b1; pst_allint = 1'b1; run_vec("R4 fiq masked");
        defaults(); req_fiq = 1'b1; run_vec("R4 fiq open");
    endtask

    task automatic t_lower();
        defaults(); cur_el = 2'd2; irq_tgt_el = 2'd1; req_nmi = 1'b1; req_irq = 1'b1;
        run_vec("R1 irq below");
        defaults(); cur_el = 2'd2; fiq_tgt_el = 2'd1; req_fiq = 1'b1;
        run_vec("R1 fiq below");
        defaults(); cur_el = 2'd2; req_vinmi = 1'b1; req_virq = 1'b1;
        run_vec("R1 virtual below");
        defaults(); cur_el = 2'd0; irq_tgt_el = 2'd3; req_irq = 1'b1; spint_mask = 4'h8;
        run_vec("R1 irq above");
    endtask

    task automatic t_virtual();
        defaults(); req_vinmi = 1'b1; hyp_irq_route = 1'b0; run_vec("R5 vinmi unrouted");
        defaults(); req_vinmi = 1'b1; host_mode = 1'b1;     run_vec("R5 vinmi host");
        defaults(); req_vfnmi = 1'b1; hyp_fiq_route = 1'b0; run_vec("R5 vfnmi unrouted");
        defaults(); req_vfnmi = 1'b1; pst_allint = 1'b1;    run_vec("R5 vfnmi masked");
        defaults(); req_vinmi = 1'b1; pst_i = 1'b1;         run_vec("R5 vinmi ignores I");
        defaults(); req_virq = 1'b1; pst_i = 1'b1;          run_vec("R5 virq I set");
        defaults(); req_vfiq = 1'b1; cur_el = 2'd0; pst_allint = 1'b1; run_vec("R5 vfiq mask off-level");
    endtask

    task automatic t_priority();
        defaults();
        for (int drop = 0; drop < 8; drop++) begin
            defaults();
            {req_nmi, req_vinmi, req_vfnmi, req_fiq, req_irq, req_virq, req_vfiq} = 7'h7F >> drop;
            run_vec("R6 priority");
        end
    endtask

    task automatic t_fold();
        defaults(); nmi_en = 4'h0; req_nmi = 1'b1;   run_vec("R7 nmi as irq");
        defaults(); nmi_en = 4'h0; req_nmi = 1'b1; pst_i = 1'b1; run_vec("R7 nmi blocked by I");
        defaults(); nmi_en = 4'h0; req_vinmi = 1'b1; run_vec("R7 vinmi as virq");
        defaults(); nmi_en = 4'h0; req_vfnmi = 1'b1; run_vec("R7 vfnmi as vfiq");
        defaults(); nmi_en = 4'h0; req_vfnmi = 1'b1; req_vinmi = 1'b1; req_nmi = 1'b1;
        run_vec("R7 folded order");
    endtask

    task automatic t_entry_allint();
        defaults(); cur_el = 2'd1; fiq_tgt_el = 2'd3; spint_mask = 4'h7; req_fiq = 1'b1;
        run_vec("R10 fiq tgt3 spint0");
        defaults(); cur_el = 2'd1; fiq_tgt_el = 2'd3; spint_mask = 4'h8; req_fiq = 1'b1;
        run_vec("R10 fiq tgt3 spint1");
        defaults(); spint_mask = 4'h2; req_virq = 1'b1; run_vec("R10 virtual level1");
    endtask

    task automatic t_pulse();
        defaults(); req_irq = 1'b1;
        @(posedge clk); @(negedge clk);
        cmp("R11 first take", int'(take), 1);
        cmp("R11 idx", int'(exc_idx), 5);
        req_irq = 1'b0; req_fiq = 1'b1;
        @(posedge clk); @(negedge clk);
        cmp("R11 gap", int'(take), 0);
        cmp("R11 idx held", int'(exc_idx), 5);
        @(posedge clk); @(negedge clk);
        cmp("R11 second take", int'(take), 1);
        cmp("R11 new idx", int'(exc_idx), 6);
        clr_reqs();
        @(posedge clk); @(negedge clk);
        cmp("R11 end", int'(take), 0);
        cmp("R11 vec held", int'(vec_off), 'h100);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_sweep();
        t_lower();
        t_virtual();
        t_priority();
        t_fold();
        t_entry_allint();
        t_pulse();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule